// File: doc/BRIEF.md
# Streaming Multi-Keyword Byte Scanner

This block scans a byte stream for a fixed set of keywords, all at once, using a single keyword automaton. The automaton is a tree of shared-prefix states rooted in an idle state, plus a fallback link from every state. It takes one payload byte per handshake and moves exactly one table step per byte. When a byte completes one or more keywords, the block flags a match on the next cycle with a one-hot-per-keyword vector. Several bits may be set together when keywords overlap. A fallback link lets the scan go on after a mismatch without looking at earlier bytes again, so a keyword is found wherever it starts in the payload.

The keyword table is fixed at build time. It holds "he", "she", "his" and "her", and the vector bit of each is given below. A start-of-packet pulse drops any partial progress so that keywords never span two packets. By default the table lookup is combinational and the block never stalls. A parameter selects a registered lookup that holds off the sender for one cycle after each byte.

Top module: `ac_matcher`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `match_o` is 0, `match_vec_o` is 0 and, in the default variant, `byte_ready_o` is 1.
- R2: With the combinational lookup (REG_LOOKUP=0), `byte_ready_o` stays 1 and a byte is accepted on every clock edge where `byte_valid_i` is 1, with no idle cycle between bytes.
- R3: Each keyword is reported on its own bit of `match_vec_o`: bit 0 for "he", bit 1 for "she", bit 2 for "his", bit 3 for "her". `match_o` is 1 exactly when any bit of `match_vec_o` is 1.
- R4: A match is reported on the cycle after the edge that accepts the keyword's last byte, and it lasts that single cycle unless the next accepted byte also ends a keyword.
- R5: When a byte ends several keywords at once, all of them are reported in the same cycle. Ending "she" sets bits 1 and 0 together (vector 4'b0011).
- R6: After a mismatch the scan falls back along the longest suffix already seen that is also a keyword prefix. For example, "shis" reports "his", "hhe" reports "he", and in "sher" the final "r" reports "her".
- R7: A cycle with `byte_valid_i` 0 and `sop_i` 0 leaves the scan progress unchanged and reports no match. A keyword split by idle cycles is still found.
- R8: `sop_i`, when taken while `byte_ready_o` is 1, returns the scan to the idle state. A byte accepted in the same cycle is scanned as the first byte of the new packet, so no keyword spans the pulse.
- R9: Every payload byte is examined, so a keyword is found at any offset after arbitrary unrelated bytes.
- R10: With the registered lookup (REG_LOOKUP=1), `byte_ready_o` is 0 on the cycle after each accepted byte and 1 again the cycle after. The match for a byte is reported two cycles after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_i | input | 1 | Start-of-packet pulse; returns the scan to idle |
| byte_valid_i | input | 1 | Payload byte present |
| byte_i | input | BYTE_W | Payload byte |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| match_o | output | 1 | At least one keyword ended on the previous byte |
| match_vec_o | output | NUM_PATS | One bit per keyword that ended |

## Verification
In the default variant every result is due one edge after the accepting edge, because the new state and the keyword vector are registered together. The bench drives inputs on the falling edge, lets one rising edge pass, and reads `match_vec_o` on the next falling edge. It then compares the value with a model that checks which keywords the bytes since the last start pulse end with. In the registered variant the vector arrives one edge later, and the bench reads `byte_ready_o` and `match_vec_o` at each falling edge of that two-cycle window.

// File: rtl/ac_pkg.sv
package ac_pkg;

   localparam int AC_BYTE_W     = 8;
   localparam int AC_NUM_STATES = 9;
   localparam int AC_NUM_PATS   = 4;
   localparam int AC_NUM_EDGES  = 8;
   localparam int AC_MAX_DEPTH  = 3;
   localparam int AC_STATE_W    = $clog2(AC_NUM_STATES);

   typedef logic [AC_STATE_W-1:0]  ac_state_t;
   typedef logic [AC_BYTE_W-1:0]   ac_byte_t;
   typedef logic [AC_NUM_PATS-1:0] ac_pvec_t;

   localparam ac_state_t AC_ROOT = '0;

   typedef struct packed {
      ac_state_t src;
      ac_byte_t  sym;
      ac_state_t dst;
   } ac_edge_t;

   // trie states: 0 idle, 1 "h", 2 "he", 3 "hi", 4 "his", 5 "her",
   // 6 "s", 7 "sh", 8 "she"
   function automatic ac_edge_t ac_edge(input int idx);
      ac_edge_t e;
      e = '{src: AC_ROOT, sym: '0, dst: AC_ROOT};
      case (idx)
         0: e = '{src: ac_state_t'(0), sym: 8'h68, dst: ac_state_t'(1)};
         1: e = '{src: ac_state_t'(1), sym: 8'h65, dst: ac_state_t'(2)};
         2: e = '{src: ac_state_t'(1), sym: 8'h69, dst: ac_state_t'(3)};
         3: e = '{src: ac_state_t'(3), sym: 8'h73, dst: ac_state_t'(4)};
         4: e = '{src: ac_state_t'(2), sym: 8'h72, dst: ac_state_t'(5)};
         5: e = '{src: ac_state_t'(0), sym: 8'h73, dst: ac_state_t'(6)};
         6: e = '{src: ac_state_t'(6), sym: 8'h68, dst: ac_state_t'(7)};
         7: e = '{src: ac_state_t'(7), sym: 8'h65, dst: ac_state_t'(8)};
         default: e = '{src: AC_ROOT, sym: '0, dst: AC_ROOT};
      endcase
      return e;
   endfunction

   // fallback link: longest proper suffix that is also a trie prefix
   function automatic ac_state_t ac_fail(input ac_state_t s);
      ac_state_t f;
      case (s)
         ac_state_t'(4): f = ac_state_t'(6);
         ac_state_t'(7): f = ac_state_t'(1);
         ac_state_t'(8): f = ac_state_t'(2);
         default:        f = AC_ROOT;
      endcase
      return f;
   endfunction

   // keyword ending exactly at a state (bit0 he, bit1 she, bit2 his, bit3 her)
   function automatic ac_pvec_t ac_own(input ac_state_t s);
      ac_pvec_t v;
      case (s)
         ac_state_t'(2): v = 4'b0001;
         ac_state_t'(8): v = 4'b0010;
         ac_state_t'(4): v = 4'b0100;
         ac_state_t'(5): v = 4'b1000;
         default:        v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/ac_goto.sv
module ac_goto
   import ac_pkg::*;
#(
   parameter int NUM_EDGES = AC_NUM_EDGES
) (
   input  ac_state_t state_i,
   input  ac_byte_t  sym_i,
   output logic      hit_o,
   output ac_state_t dst_o
);

   if (NUM_EDGES < 1 || NUM_EDGES > AC_NUM_EDGES) begin : g_bad_edges
      $error("ac_goto: NUM_EDGES out of range");
   end

   logic [NUM_EDGES-1:0] edge_hit;
   ac_state_t            edge_dst [NUM_EDGES];

   for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
      localparam ac_edge_t ED = ac_edge(e);
      assign edge_hit[e] = (state_i == ED.src) && (sym_i == ED.sym);
      assign edge_dst[e] = ED.dst;
   end

   always_comb begin
      dst_o = AC_ROOT;
      for (int e = 0; e < NUM_EDGES; e++) begin
         if (edge_hit[e]) dst_o = edge_dst[e];
      end
   end

   assign hit_o = |edge_hit;

endmodule

// File: rtl/ac_next_state.sv
module ac_next_state
   import ac_pkg::*;
#(
   parameter int DEPTH = AC_MAX_DEPTH
) (
   input  ac_state_t cur_i,
   input  ac_byte_t  sym_i,
   output ac_state_t nxt_o
);

   localparam int PROBES = DEPTH + 1;

   if (DEPTH < AC_MAX_DEPTH) begin : g_bad_depth
      $error("ac_next_state: DEPTH shorter than the deepest keyword");
   end

   ac_state_t         probe [PROBES];
   logic [PROBES-1:0] hit;
   ac_state_t         dst   [PROBES];

   always_comb begin
      probe[0] = cur_i;
      for (int k = 1; k < PROBES; k++) begin
         probe[k] = ac_fail(probe[k-1]);
      end
   end

   for (genvar k = 0; k < PROBES; k++) begin : g_probe
      ac_goto #(.NUM_EDGES(AC_NUM_EDGES)) u_goto (
         .state_i (probe[k]),
         .sym_i   (sym_i),
         .hit_o   (hit[k]),
         .dst_o   (dst[k])
      );
   end

   // the shallowest fallback level that has an edge wins; none means idle
   always_comb begin
      nxt_o = AC_ROOT;
      for (int k = PROBES - 1; k >= 0; k--) begin
         if (hit[k]) nxt_o = dst[k];
      end
   end

endmodule

// File: rtl/ac_report.sv
module ac_report
   import ac_pkg::*;
#(
   parameter int DEPTH = AC_MAX_DEPTH
) (
   input  ac_state_t state_i,
   output ac_pvec_t  hits_o
);

   ac_state_t walk;

   // a state reports its own keyword and every keyword on its fallback chain
   always_comb begin
      walk   = state_i;
      hits_o = '0;
      for (int k = 0; k <= DEPTH; k++) begin
         hits_o = hits_o | ac_own(walk);
         walk   = ac_fail(walk);
      end
   end

endmodule

// File: rtl/ac_matcher.sv
module ac_matcher
   import ac_pkg::*;
#(
   parameter int NUM_PATS   = AC_NUM_PATS,
   parameter int BYTE_W     = AC_BYTE_W,
   parameter bit REG_LOOKUP = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sop_i,
   input  logic                byte_valid_i,
   input  logic [BYTE_W-1:0]   byte_i,
   output logic                byte_ready_o,
   output logic                match_o,
   output logic [NUM_PATS-1:0] match_vec_o
);

   localparam int DEPTH = AC_MAX_DEPTH;

   if (NUM_PATS != AC_NUM_PATS) begin : g_bad_pats
      $error("ac_matcher: NUM_PATS must equal the table keyword count");
   end
   if (BYTE_W != AC_BYTE_W) begin : g_bad_byte
      $error("ac_matcher: BYTE_W must equal the table symbol width");
   end

   ac_state_t state_q;
   ac_state_t step_from;
   ac_state_t step_next;
   ac_byte_t  step_sym;
   logic      step_en;
   logic      sop_take;
   ac_pvec_t  step_hits;
   ac_pvec_t  vec_q;

   if (!REG_LOOKUP) begin : g_comb
      assign byte_ready_o = 1'b1;
      assign step_en      = byte_valid_i;
      assign step_sym     = byte_i;
      assign step_from    = sop_i ? AC_ROOT : state_q;
   end else begin : g_reg
      logic     busy_q;
      logic     sop_q;
      ac_byte_t sym_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            sop_q  <= 1'b0;
            sym_q  <= '0;
         end else begin
            busy_q <= byte_valid_i && !busy_q;
            if (byte_valid_i && !busy_q) begin
               sym_q <= byte_i;
               sop_q <= sop_i;
            end
         end
      end

      assign byte_ready_o = !busy_q;
      assign step_en      = busy_q;
      assign step_sym     = sym_q;
      assign step_from    = sop_q ? AC_ROOT : state_q;
   end

   assign sop_take = sop_i && byte_ready_o;

   ac_next_state #(.DEPTH(DEPTH)) u_next (
      .cur_i (step_from),
      .sym_i (step_sym),
      .nxt_o (step_next)
   );

   ac_report #(.DEPTH(DEPTH)) u_report (
      .state_i (step_next),
      .hits_o  (step_hits)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= AC_ROOT;
         vec_q   <= '0;
      end else begin
         vec_q <= step_en ? step_hits : '0;
         if (step_en) begin
            state_q <= step_next;
         end else if (sop_take) begin
            state_q <= AC_ROOT;
         end
      end
   end

   assign match_vec_o = vec_q;
   assign match_o     = |vec_q;

endmodule

// File: rtl/ac_matcher_chk.sv
module ac_matcher_chk
   import ac_pkg::*;
#(
   parameter int NUM_PATS   = AC_NUM_PATS,
   parameter bit REG_LOOKUP = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sop_i,
   input logic                byte_valid_i,
   input logic                byte_ready_o,
   input logic [NUM_PATS-1:0] match_vec_o,
   input ac_state_t           state_q
);

   AST_STATE_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      state_q < ac_state_t'(AC_NUM_STATES)); // R6

   AST_IDLE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_LOOKUP && !byte_valid_i) |=> (match_vec_o == '0)); // R7

   AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_LOOKUP && !byte_valid_i && !sop_i) |=> $stable(state_q)); // R7

   AST_SHE_ALSO_HE: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec_o[1] |-> match_vec_o[0]); // R5

   AST_AT_MOST_TWO_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(match_vec_o) <= 2); // R3

   AST_SOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sop_i && byte_ready_o && !byte_valid_i) |=> (state_q == AC_ROOT)); // R8

   AST_REG_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_LOOKUP && byte_valid_i && byte_ready_o) |=> !byte_ready_o); // R10

endmodule

bind ac_matcher ac_matcher_chk #(
   .NUM_PATS   (NUM_PATS),
   .REG_LOOKUP (REG_LOOKUP)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sop_i        (sop_i),
   .byte_valid_i (byte_valid_i),
   .byte_ready_o (byte_ready_o),
   .match_vec_o  (match_vec_o),
   .state_q      (state_q)
);

// File: tb/ac_matcher_bench.sv
module ac_matcher_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sop_i = 1'b0;
   logic       byte_valid_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic       byte_ready_o;
   logic       match_o;
   logic [3:0] match_vec_o;

   logic       r_sop = 1'b0;
   logic       r_valid = 1'b0;
   logic [7:0] r_byte = '0;
   logic       r_ready;
   logic       r_match;
   logic [3:0] r_vec;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   // model history: newest byte in h0, bytes seen since last start pulse in cnt
   logic [7:0] h0 = '0, h1 = '0, h2 = '0;
   int         cnt = 0;

   always #10 clk = ~clk;

   ac_matcher u_ac_matcher (
      .clk (clk), .rst_n (rst_n), .sop_i (sop_i),
      .byte_valid_i (byte_valid_i), .byte_i (byte_i),
      .byte_ready_o (byte_ready_o), .match_o (match_o),
      .match_vec_o (match_vec_o)
   );

   ac_matcher #(.REG_LOOKUP(1'b1)) u_ac_matcher_reg (
      .clk (clk), .rst_n (rst_n), .sop_i (r_sop),
      .byte_valid_i (r_valid), .byte_i (r_byte),
      .byte_ready_o (r_ready), .match_o (r_match),
      .match_vec_o (r_vec)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] model_vec();
      logic [3:0] v;
      v = '0;
      if (cnt >= 2 && h1 == "h" && h0 == "e")                v[0] = 1'b1;
      if (cnt >= 3 && h2 == "s" && h1 == "h" && h0 == "e")   v[1] = 1'b1;
      if (cnt >= 3 && h2 == "h" && h1 == "i" && h0 == "s")   v[2] = 1'b1;
      if (cnt >= 3 && h2 == "h" && h1 == "e" && h0 == "r")   v[3] = 1'b1;
      return v;
   endfunction

   // called on a falling edge; one cycle of stimulus, result read one edge later
   task automatic step(input bit v, input bit s, input logic [7:0] b, input string req);
      logic [3:0] exp;
      byte_valid_i = v;
      sop_i        = s;
      byte_i       = b;
      @(negedge clk);
      if (s) cnt = 0;
      if (v) begin
         h2 = h1; h1 = h0; h0 = b; cnt++;
      end
      exp = v ? model_vec() : 4'b0000;
      chk(req, 32'(match_vec_o), 32'(exp));
      chk({req, " flag"}, 32'(match_o), 32'(exp != 4'b0000));
      byte_valid_i = 1'b0;
      sop_i        = 1'b0;
   endtask

   task automatic feed(input string s, input bit sop_first, input string req);
      for (int i = 0; i < s.len(); i++) begin
         step(1'b1, sop_first && (i == 0), s[i], req);
      end
   endtask

   task automatic t_reset();
      chk("R1 flag in reset", 32'(match_o), 0);
      chk("R1 vector in reset", 32'(match_vec_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flag after reset", 32'(match_o), 0);
      chk("R1 vector after reset", 32'(match_vec_o), 0);
      chk("R1 ready after reset", 32'(byte_ready_o), 1);
   endtask

   task automatic t_each_keyword();
      feed("he", 1'b1, "R3 he");
      feed("she", 1'b1, "R3 she");
      feed("his", 1'b1, "R3 his");
      feed("her", 1'b1, "R3 her");
   endtask

   task automatic t_timing();
      step(1'b1, 1'b1, "h", "R4 first byte");
      chk("R4 nothing after h", 32'(match_vec_o), 0);
      step(1'b1, 1'b0, "e", "R4 last byte");
      chk("R4 he one cycle after", 32'(match_vec_o), 32'h1);
      step(1'b0, 1'b0, "x", "R4 pulse ends");
      chk("R4 one cycle wide", 32'(match_vec_o), 0);
   endtask

   task automatic t_overlap();
      feed("she", 1'b1, "R5 she");
      chk("R5 she and he together", 32'(match_vec_o), 32'h3);
   endtask

   task automatic t_fallback();
      feed("shis", 1'b1, "R6 shis");
      chk("R6 his after sh", 32'(match_vec_o), 32'h4);
      feed("hhe", 1'b1, "R6 hhe");
      chk("R6 he after h", 32'(match_vec_o), 32'h1);
      feed("sher", 1'b1, "R6 sher");
      chk("R6 her after she", 32'(match_vec_o), 32'h8);
      feed("hishe", 1'b1, "R6 hishe");
   endtask

   task automatic t_gap();
      step(1'b1, 1'b1, "h", "R7 before gap");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "e", "R7 idle byte ignored");
      step(1'b1, 1'b0, "e", "R7 after gap");
      chk("R7 he across gap", 32'(match_vec_o), 32'h1);
   endtask

   task automatic t_sop();
      feed("sh", 1'b1, "R8 prefix");
      step(1'b0, 1'b1, 8'h00, "R8 pulse alone");
      step(1'b1, 1'b0, "e", "R8 no she across pulse");
      chk("R8 no keyword across pulse", 32'(match_vec_o), 0);
      step(1'b1, 1'b1, "h", "R8 prefix h");
      step(1'b1, 1'b1, "e", "R8 pulse with byte");
      chk("R8 no he across pulse", 32'(match_vec_o), 0);
   endtask

   task automatic t_stream();
      byte_valid_i = 1'b1;
      chk("R2 ready while streaming", 32'(byte_ready_o), 1);
      feed("ahxhe", 1'b1, "R2 back to back");
      chk("R2 ready after stream", 32'(byte_ready_o), 1);
   endtask

   task automatic t_anywhere();
      feed("qzx7k1hhiherxxsheqhis", 1'b1, "R9 keywords at any offset");
   endtask

   task automatic t_registered();
      chk("R10 ready when idle", 32'(r_ready), 1);
      r_sop = 1'b1; r_valid = 1'b1; r_byte = "h";
      @(negedge clk);
      r_sop = 1'b0; r_valid = 1'b0;
      chk("R10 stalls after h", 32'(r_ready), 0);
      @(negedge clk);
      chk("R10 ready again", 32'(r_ready), 1);
      chk("R10 nothing after h", 32'(r_vec), 0);
      r_valid = 1'b1; r_byte = "e";
      @(negedge clk);
      r_valid = 1'b0;
      chk("R10 stalls after e", 32'(r_ready), 0);
      chk("R10 not yet after one cycle", 32'(r_vec), 0);
      @(negedge clk);
      chk("R10 he two cycles after", 32'(r_vec), 32'h1);
      chk("R10 flag two cycles after", 32'(r_match), 1);
      @(negedge clk);
      chk("R10 pulse ends", 32'(r_vec), 0);
   endtask

   initial begin
      t_reset();
      t_each_keyword();
      t_timing();
      t_overlap();
      t_fallback();
      t_gap();
      t_sop();
      t_stream();
      t_anywhere();
      t_registered();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual still running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule